// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Front End

This block is the command side of a 512-byte serial EEPROM that answers an SPI master in clock mode 0 or mode 3. A fast system clock oversamples chip select, serial clock and serial data in. Edge detectors turn these into rise, fall, select and deselect events. Because of this the master may pause its clock at any point and resume later without any loss of state. The block decodes single-byte commands and collects a two-byte address. It streams stored bytes out while the address steps forward, and it gathers write data into a page buffer. That buffer is copied into the behavioural storage array only when the master ends the frame exactly on a byte boundary.

After a commit, a counter models the self-timed programming delay. While it runs, only the status command is served, and the status reads back as all ones. A three-bit protection code, written through its own command, shields part of the array from writes. The code can cover one quarter, the lower half, the first page or the last page. The serial output has a separate enable, so the chip level can build a tri-state pad. Reads can start anywhere. Writes always stay inside one 16-byte page.

Top module: `spi_eeprom_slave`

## Requirements
- R1: `miso_en` is low while reset is asserted, while chip select is high, and during command and address bits. The output is enabled only while read data or status is being shifted.
- R2: Nothing is accepted after reset until a high-to-low transition of chip select has been seen. A frame that was already low when reset was released gets no response.
- R3: Command 03h followed by a 16-bit address (MSB first) returns the byte at address bits [8:0]. Address bits [15:9] are ignored. Data leaves MSB first, and each bit changes after a falling clock edge, so the master samples it on the next rising edge.
- R4: During a read, the address advances after every byte for as long as clocks continue, and it wraps from 1FFh to 000h.
- R5: Command 02h is accepted only while the write-enable flag is set. Command 06h sets the flag and command 04h clears it. A write attempted while the flag is clear changes no stored byte.
- R6: A write places successive bytes at successive addresses inside the 16-byte page of its start address. Past the last byte of the page it continues at the page's first byte, so a later byte overwrites an earlier one to the same location.
- R7: Buffered write data is committed only when chip select rises immediately after the eighth bit of a data byte. A rise at any other point discards the whole frame.
- R8: For WR_CYCLES system clocks after a commit, status command 05h returns FFh. Every other command in that window is ignored, and a read gives no output.
- R9: When no write is pending, command 05h returns {5'b00000, code}, where code is the active protection code.
- R10: A commit clears the write-enable flag. A command byte that follows 06h in the same frame is ignored.
- R11: Command 01h followed by a byte whose bits [2:0] are the code sets the protection at a byte-boundary deselect, under the same conditions as a write. The code meanings are: 0 none; 1 000h-07Fh; 2 080h-0FFh; 3 100h-17Fh; 4 180h-1FFh; 5 000h-0FFh; 6 000h-00Fh; 7 1F0h-1FFh. Writes to protected addresses are skipped and other bytes of the same page are still written.
- R12: An opcode outside the six defined ones makes the block ignore the rest of the frame, including later command bytes. The output stays disabled.
- R13: Mode 3 (clock idle high) gives the same results as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in, sampled on rising serial clock |
| miso | output | 1 | Serial data out |
| miso_en | output | 1 | Drive enable for the serial data out pad |

## Verification
The bench keeps ADDR_W at 9 and PAGE_W at 4. With these values the 1FFh-to-000h read wrap, the last-page protection code and a 17-byte page overrun are all reachable with real addresses. WR_CYCLES is raised to 1000. This keeps the busy window open long enough for a whole status frame followed by a whole read frame, so the all-ones status and the ignored read are both seen before programming finishes. Each write is followed by a wait just past that window, so read-backs always observe the committed array.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] PH_IGN = 3'd0, PH_OP = 3'd1, PH_AH = 3'd2, PH_AL = 3'd3,
                         PH_RD  = 3'd4, PH_WD = 3'd5, PH_LK = 3'd6, PH_ST = 3'd7;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic armed, rd_op, at_edge, wel;
  logic [2:0] phase, bitcnt, obit, lock, lk_new;
  logic [6:0] sr;
  logic [7:0] oreg;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] idx;
  logic [PAGE-1:0] pvalid;
  logic [CNT_W-1:0] wtimer;
  logic [7:0] pbuf [PAGE];
  logic [7:0] mem [DEPTH];

  wire cs_fall   = cs_q[2] & ~cs_q[1];
  wire cs_rise   = ~cs_q[2] & cs_q[1];
  wire sck_rise  = sck_q[1] & ~sck_q[2];
  wire sck_fall  = ~sck_q[1] & sck_q[2];
  wire active    = armed & ~cs_q[1];
  wire [7:0] byte_in = {sr, si_q[1]};
  wire byte_done = active & sck_rise & (bitcnt == 3'd7);
  wire busy      = (wtimer != '0);
  wire wr_phase  = (phase == PH_WD);
  wire ign_phase = (phase == PH_IGN);
  wire out_phase = (phase == PH_RD) | (phase == PH_ST);
  wire commit    = cs_rise & armed & at_edge & (wr_phase | (phase == PH_LK));

  assign miso    = oreg[7];
  assign miso_en = active & out_phase;

  function automatic logic locked(input logic [2:0] c, input logic [ADDR_W-1:0] a);
    case (c)
      3'd1:    return a[ADDR_W-1 -: 2] == 2'd0;
      3'd2:    return a[ADDR_W-1 -: 2] == 2'd1;
      3'd3:    return a[ADDR_W-1 -: 2] == 2'd2;
      3'd4:    return a[ADDR_W-1 -: 2] == 2'd3;
      3'd5:    return ~a[ADDR_W-1];
      3'd6:    return a[ADDR_W-1:PAGE_W] == '0;
      3'd7:    return &a[ADDR_W-1:PAGE_W];
      default: return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '0; sck_q <= '0; si_q <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0; phase <= PH_IGN; bitcnt <= '0; sr <= '0; rd_op <= 1'b0;
      addr <= '0; idx <= '0; pvalid <= '0; at_edge <= 1'b0; lock <= '0;
      lk_new <= '0; wel <= 1'b0; wtimer <= '0; oreg <= '0; obit <= '0;
    end else begin
      if (busy) wtimer <= wtimer - CNT_W'(1);
      if (cs_fall) begin
        armed <= 1'b1; phase <= PH_OP; bitcnt <= '0; obit <= '0;
        at_edge <= 1'b0; pvalid <= '0;
      end else if (cs_rise) begin
        phase <= PH_IGN; at_edge <= 1'b0;
        if (commit) begin
          wel <= 1'b0;
          wtimer <= CNT_W'(WR_CYCLES);
          if (phase == PH_LK) lock <= lk_new;
        end
      end else if (active) begin
        if (sck_rise) begin
          sr <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
          at_edge <= 1'b0;
          if (bitcnt == 3'd7)
            case (phase)
              PH_OP:
                if (busy && byte_in != 8'h05) phase <= PH_IGN;
                else
                  case (byte_in)
                    8'h06: begin wel <= 1'b1; phase <= PH_IGN; end
                    8'h04: begin wel <= 1'b0; phase <= PH_IGN; end
                    8'h03: begin rd_op <= 1'b1; phase <= PH_AH; end
                    8'h02: begin rd_op <= 1'b0; phase <= wel ? PH_AH : PH_IGN; end
                    8'h05: phase <= PH_ST;
                    8'h01: phase <= wel ? PH_LK : PH_IGN;
                    default: phase <= PH_IGN;
                  endcase
              PH_AH: begin addr <= ADDR_W'({byte_in, 8'h00}); phase <= PH_AL; end
              PH_AL: begin
                addr[7:0] <= byte_in;
                idx <= byte_in[PAGE_W-1:0];
                phase <= rd_op ? PH_RD : PH_WD;
              end
              PH_WD: begin pvalid[idx] <= 1'b1; idx <= idx + PAGE_W'(1); at_edge <= 1'b1; end
              PH_LK: begin lk_new <= byte_in[2:0]; at_edge <= 1'b1; end
              default: ;
            endcase
        end
        if (sck_fall && out_phase) begin
          obit <= obit + 3'd1;
          if (obit != 3'd0) oreg <= oreg << 1;
          else if (phase == PH_RD) begin oreg <= mem[addr]; addr <= addr + ADDR_W'(1); end
          else oreg <= busy ? 8'hFF : {5'b00000, lock};
        end
      end
    end

  always_ff @(posedge clk)
    if (byte_done && wr_phase) pbuf[idx] <= byte_in;

  always_ff @(posedge clk)
    if (commit && wr_phase)
      for (int i = 0; i < PAGE; i++)
        if (pvalid[i] && !locked(lock, {addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}))
          mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso_en,
  input logic       commit,
  input logic       busy,
  input logic       wel,
  input logic       ign_phase,
  input logic       wr_phase,
  input logic [2:0] bitcnt
);
  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !miso_en);

  a_r7_commit_on_byte_edge: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> bitcnt == 3'd0);

  a_r8_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);

  a_r10_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wel);

  a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> wel);

  a_r12_ignored_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ign_phase |-> !miso_en);
endmodule

bind spi_eeprom_slave eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_en(miso_en), .commit(commit),
  .busy(busy), .wel(wel), .ign_phase(ign_phase), .wr_phase(wr_phase), .bitcnt(bitcnt)
);

// File: tb/sim_spi_eeprom_slave.sv
module sim_spi_eeprom_slave;
  localparam int HP  = 6;
  localparam int WRC = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_en;
  int errors = 0, checks = 0;
  bit mode3 = 1'b0;
  logic [7:0] expq[$];
  string tagq[$];
  logic [7:0] wb [17];
  logic [7:0] eb [4];
  logic [7:0] msh = '0;
  int mcnt = 0;
  logic [7:0] mexp;
  string mtag;

  spi_eeprom_slave #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_en(miso_en)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) mcnt = 0;
    else if (miso_en) begin
      msh = {msh[6:0], miso};
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (expq.size() == 0) check(1'b0, "R1 unexpected output byte", msh, 0);
        else begin
          mexp = expq.pop_front();
          mtag = tagq.pop_front();
          check(msh == mexp, mtag, msh, mexp);
        end
      end
    end
  end

  task automatic wc(input int n); repeat (n) @(negedge clk); endtask
  task automatic sbit(input logic b);
    if (mode3) sck = 1'b0;
    mosi = b; wc(HP); sck = 1'b1; wc(HP);
    if (!mode3) sck = 1'b0;
  endtask
  task automatic sbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
  endtask
  task automatic sel(); wc(1); cs_n = 1'b0; wc(HP); endtask
  task automatic desel(); wc(HP); cs_n = 1'b1; wc(4 * HP); endtask
  task automatic cmd(input logic [7:0] op); sel(); sbyte(op); desel(); endtask
  task automatic idle(); wc(WRC + 20); endtask
  task automatic pwrite(input logic [15:0] a, input int n);
    sel(); sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int k = 0; k < n; k++) sbyte(wb[k]);
    desel();
  endtask
  task automatic wr1(input logic [15:0] a, input logic [7:0] d); wb[0] = d; pwrite(a, 1); endtask
  task automatic pread(input logic [15:0] a, input int n, input string tag);
    sel(); sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      expq.push_back(eb[k]); tagq.push_back(tag); sbyte(8'h00);
    end
    desel();
  endtask
  task automatic rd1(input logic [15:0] a, input logic [7:0] e, input string tag);
    eb[0] = e; pread(a, 1, tag);
  endtask
  task automatic stat(input logic [7:0] e, input string tag);
    sel(); sbyte(8'h05); expq.push_back(e); tagq.push_back(tag); sbyte(8'h00); desel();
  endtask
  task automatic setlock(input logic [7:0] c);
    cmd(8'h06); sel(); sbyte(8'h01); sbyte(c); desel(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wc(5);
    check(miso_en == 1'b0, "R1 disabled in reset", miso_en, 0);
    rst_n = 1'b1; wc(5);
    // R2: select was low before reset released, so this frame is not seen
    sbyte(8'h03); sbyte(8'h00); sbyte(8'h10); sbyte(8'h00);
    check(miso_en == 1'b0, "R2 no response before select edge", miso_en, 0);
    desel();
    check(miso_en == 1'b0, "R1 disabled when deselected", miso_en, 0);

    cmd(8'h06);
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
    pwrite(16'h0010, 4); idle();
    eb[0] = 8'h11; eb[1] = 8'h22; eb[2] = 8'h33; eb[3] = 8'h44;
    pread(16'h0010, 4, "R3 read back");
    pread(16'hFE10, 2, "R3 upper address bits ignored");

    wr1(16'h0010, 8'hAA); idle();
    rd1(16'h0010, 8'h11, "R5 write without enable");
    cmd(8'h06); cmd(8'h04); wr1(16'h0010, 8'hAA); idle();
    rd1(16'h0010, 8'h11, "R5 enable cleared by 04h");

    sel(); sbyte(8'h06); sbyte(8'h02); sbyte(8'h00); sbyte(8'h10); sbyte(8'hAA); desel(); idle();
    rd1(16'h0010, 8'h11, "R10 command after 06h ignored");
    cmd(8'h04);

    cmd(8'h06);
    wb[0] = 8'hA0; wb[1] = 8'hA1; wb[2] = 8'hA2; wb[3] = 8'hA3;
    pwrite(16'h002E, 4); idle();
    eb[0] = 8'hA2; eb[1] = 8'hA3; pread(16'h0020, 2, "R6 page wrap");
    eb[0] = 8'hA0; eb[1] = 8'hA1; pread(16'h002E, 2, "R6 page start bytes");

    cmd(8'h06);
    for (int k = 0; k < 17; k++) wb[k] = 8'hB0 + 8'(k);
    pwrite(16'h0030, 17);
    stat(8'hFF, "R8 busy status");
    sel(); sbyte(8'h03); sbyte(8'h00); sbyte(8'h30); sbyte(8'h00);
    check(miso_en == 1'b0, "R8 read ignored while busy", miso_en, 0);
    desel(); idle();
    stat(8'h00, "R9 idle status");
    eb[0] = 8'hC0; eb[1] = 8'hB1; pread(16'h0030, 2, "R6 overrun overwrites");

    wr1(16'h0030, 8'hEE); idle();
    rd1(16'h0030, 8'hC0, "R10 enable cleared by commit");

    cmd(8'h06);
    sel(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h20); sbyte(8'h77);
    sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1);
    desel(); idle();
    rd1(16'h0020, 8'hA2, "R7 mid-byte deselect cancels");
    sel(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h20); sbyte(8'h77); sbyte(8'h88); desel(); idle();
    eb[0] = 8'h77; eb[1] = 8'h88; pread(16'h0020, 2, "R7 boundary deselect commits");

    cmd(8'h06); wb[0] = 8'h5A; wb[1] = 8'h5B; pwrite(16'h01FE, 2); idle();
    cmd(8'h06); wb[0] = 8'hC1; wb[1] = 8'hC2; pwrite(16'h0000, 2); idle();
    eb[0] = 8'h5A; eb[1] = 8'h5B; eb[2] = 8'hC1; eb[3] = 8'hC2;
    pread(16'h01FE, 4, "R4 wrap to zero");

    setlock(8'h01);
    stat(8'h01, "R9 status shows code");
    cmd(8'h06); wr1(16'h0020, 8'h99); idle();
    rd1(16'h0020, 8'h77, "R11 lower quarter protected");
    cmd(8'h06); wr1(16'h01FE, 8'h66); idle();
    rd1(16'h01FE, 8'h66, "R11 outside protection");
    setlock(8'h07);
    stat(8'h07, "R11 code 7 set");
    cmd(8'h06); wr1(16'h01FF, 8'h44); idle();
    rd1(16'h01FF, 8'h5B, "R11 last page protected");
    cmd(8'h06); wr1(16'h0020, 8'h99); idle();
    rd1(16'h0020, 8'h99, "R11 lower quarter released");

    sel(); sbyte(8'hA5);
    check(miso_en == 1'b0, "R12 unknown opcode silent", miso_en, 0);
    sbyte(8'h06); sbyte(8'h03); sbyte(8'h00); sbyte(8'h20); sbyte(8'h00);
    check(miso_en == 1'b0, "R12 rest of frame ignored", miso_en, 0);
    desel();
    wr1(16'h0020, 8'h11); idle();
    rd1(16'h0020, 8'h99, "R12 enable inside ignored frame");

    mode3 = 1'b1; wc(1); sck = 1'b1; wc(HP);
    eb[0] = 8'h66; eb[1] = 8'h5B; pread(16'h01FE, 2, "R13 mode 3 read");
    mode3 = 1'b0; sck = 1'b0; wc(20);

    check(expq.size() == 0, "R3 all expected bytes produced", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule